// File: doc/BRIEF.md
# Shared Grøstl Permutation and Quad AES-128 Round Unit

This block holds one 512-bit state register and one round datapath that serves two jobs. In hash mode it computes the Grøstl-256 compression function f(h, m) = P(h ^ m) ^ Q(m) ^ h. The P permutation runs for ten rounds, then the Q permutation runs for ten rounds, one round per clock. In cipher mode the same 512 bits are split into four 128-bit lanes, and each lane runs an independent AES-128 encryption, one round per clock. The 64 S-boxes, the byte permutation and the GF(2^8) doubling/XOR network are the same hardware in both modes. Multiplexers change only the byte routing, the column mixing and the round key addition.

A caller sets `mode`, places its operands on the inputs and pulses `start` while the unit is idle. Round keys come from outside. The unit shows on `key_round` which round key each lane must present on `rk_in`. Before a job starts, `key_round` is 0 and that key is used for whitening. The caller can supply keys from a table or from a separate key expander. On completion `done` pulses once, and `result` holds the answer until the next job completes. Padding and the hash output transformation belong to the surrounding logic.

Top module: `hash_cipher_round`

## Requirements
- R1: While reset is asserted and just after it is released, `done` is 0, `result` is all zeros and `key_round` is 0.
- R2: In hash mode (`mode`=0), `result` equals P(h ^ m) ^ Q(m) ^ h. Here h is `chain_in` and m is `msg_in`. Byte k of a 512-bit word sits at bits [511-8k -: 8] and belongs to column k/8, row k%8. Each P round first XORs ((column << 4) ^ round) into row 0, for round = 0..9. It then substitutes every byte with the AES S-box and rotates row r left by r columns. Last, it multiplies each column by the circulant matrix whose first row is (02,02,03,04,05,03,05,07), over GF(2^8) with polynomial 0x11B.
- R3: Q differs from P only in two steps. Its round constant XORs 0xFF into every byte and then XORs ((column << 4) ^ round) into row 7. Its row rotations for rows 0..7 are 1,3,5,7,0,2,4,6.
- R4: A hash job accepted at a clock edge raises `done` after the 20th following edge.
- R5: In cipher mode (`mode`=1), lane L uses bits [511-128L -: 128] of `pt_in`, `rk_in` and `result`. Each lane computes the standard AES-128 encryption: whitening, nine full rounds, and a final round without MixColumns. For example, key 000102..0f with plaintext 00112233..eeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R6: A cipher job accepted at a clock edge raises `done` after the 10th following edge. `key_round` reads 0 while idle and reads n+1 after the n-th edge of the run (n = 0..9). Each lane must present round key `key_round` on `rk_in`.
- R7: Changing one lane's plaintext changes only that lane's ciphertext.
- R8: A `start` pulse while a job is running is ignored. The running job keeps its mode, its latency and its result.
- R9: `result` changes only in the cycle in which `done` is high and otherwise holds the last answer. A `start` in the cycle in which `done` is high is accepted.
- R10: `done` is high for exactly one cycle per job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (taken only when idle) |
| mode | input | 1 | 0 = hash compression, 1 = four-lane AES |
| chain_in | input | 512 | Chaining value h |
| msg_in | input | 512 | Message block m |
| pt_in | input | 512 | Four plaintexts, lane 0 in the top bits |
| rk_in | input | 512 | Four round keys for round `key_round` |
| key_round | output | 4 | Index of the round key required now |
| result | output | 512 | Compression output or four ciphertexts |
| done | output | 1 | One-cycle completion pulse |

## Verification
A job's completion pulse and the acceptance of the next `start` can fall in the same cycle. Also, a new `start` can arrive while a job is running. The bench chains a hash job directly off the `done` cycle of a cipher job. It then checks, in every cycle of the new run, that `result` still holds the ciphertexts, and that the new digest appears after exactly 20 edges. It also raises `start` with the opposite mode in the middle of both kinds of run, and checks that latency and result match a job with no interruption.

// File: rtl/hash_cipher_round.sv
module hash_cipher_round (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic [511:0] chain_in,
  input  logic [511:0] msg_in,
  input  logic [511:0] pt_in,
  input  logic [511:0] rk_in,
  output logic [3:0]   key_round,
  output logic [511:0] result,
  output logic         done
);
  localparam int NB = 64;
  localparam int NR = 10;

  logic         busy, mode_q;
  logic [4:0]   cnt;
  logic [511:0] state_q, acc_q, msg_q, rnd_out;
  logic [7:0]   ark [NB];
  logic [7:0]   sb  [NB];
  logic [7:0]   sh  [NB];
  logic [7:0]   m2  [NB];
  logic [7:0]   m4  [NB];
  logic         q_phase, aes_last;
  logic [3:0]   hround;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] p, inv;
    p   = gmul(a, a);
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      inv = gmul(inv, p);
      p   = gmul(p, p);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] mulsel(input int d, input logic [7:0] x1,
                                        input logic [7:0] x2, input logic [7:0] x4);
    case (d)
      0, 1:    return x2;
      2, 5:    return x2 ^ x1;
      3:       return x4;
      4, 6:    return x4 ^ x1;
      default: return x4 ^ x2 ^ x1;
    endcase
  endfunction

  assign q_phase   = cnt >= 5'(NR);
  assign hround    = q_phase ? 4'(cnt - 5'(NR)) : cnt[3:0];
  assign aes_last  = cnt == 5'(NR - 1);
  assign key_round = (busy && mode_q) ? cnt[3:0] + 4'd1 : 4'd0;

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      ark[k] = state_q[511-8*k -: 8];
      if (!mode_q) begin
        if (q_phase) ark[k] = ark[k] ^ 8'hff;
        if ((k % 8) == (q_phase ? 7 : 0))
          ark[k] = ark[k] ^ {1'b0, 3'(k / 8), hround};
      end
      sb[k] = sbox(ark[k]);
    end
  end

  always_comb begin
    int c, r, amt, a, ar, sa, src;
    for (int k = 0; k < NB; k++) begin
      c = k / 8; r = k % 8;
      amt = 0; a = 0; ar = 0; sa = 0;
      if (mode_q) begin
        a   = 2 * (c % 2) + r / 4;
        ar  = r % 4;
        sa  = (a + ar) % 4;
        src = 8 * (2 * (c / 2) + sa / 2) + ar + 4 * (sa % 2);
      end else begin
        amt = !q_phase ? r : (r < 4 ? 2 * r + 1 : 2 * (r - 4));
        src = 8 * ((c + amt) % 8) + r;
      end
      sh[k] = sb[6'(src)];
      m2[k] = xt(sh[k]);
      m4[k] = xt(m2[k]);
    end
  end

  always_comb begin
    int c, r, b, rr;
    logic [7:0] hm, am;
    rnd_out = '0;
    for (int k = 0; k < NB; k++) begin
      c = k / 8; r = k % 8;
      b = 8 * c + 4 * (r / 4); rr = r % 4;
      hm = 8'h00;
      for (int j = 0; j < 8; j++)
        hm = hm ^ mulsel((j - r + 8) % 8, sh[6'(8*c+j)], m2[6'(8*c+j)], m4[6'(8*c+j)]);
      am = m2[6'(b+rr)] ^ m2[6'(b+(rr+1)%4)] ^ sh[6'(b+(rr+1)%4)] ^
           sh[6'(b+(rr+2)%4)] ^ sh[6'(b+(rr+3)%4)];
      rnd_out[511-8*k -: 8] = mode_q ? ((aes_last ? sh[k] : am) ^ rk_in[511-8*k -: 8]) : hm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mode_q  <= 1'b0;
      cnt     <= '0;
      state_q <= '0;
      acc_q   <= '0;
      msg_q   <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          mode_q <= mode;
          cnt    <= '0;
          if (mode) begin
            state_q <= pt_in ^ rk_in;
          end else begin
            state_q <= chain_in ^ msg_in;
            acc_q   <= chain_in;
            msg_q   <= msg_in;
          end
        end
      end else begin
        cnt     <= cnt + 5'd1;
        state_q <= rnd_out;
        if (mode_q) begin
          if (cnt == 5'(NR - 1)) begin
            busy   <= 1'b0;
            result <= rnd_out;
            done   <= 1'b1;
          end
        end else if (cnt == 5'(NR - 1)) begin
          state_q <= msg_q;
          acc_q   <= acc_q ^ rnd_out;
        end else if (cnt == 5'(2 * NR - 1)) begin
          busy   <= 1'b0;
          result <= acc_q ^ rnd_out;
          done   <= 1'b1;
        end
      end
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mode_q));
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < (mode_q ? 5'(NR) : 5'(2 * NR)));
  a_r6_key_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> key_round == 4'd0);
endmodule

// File: tb/hash_cipher_round_tb.sv
module hash_cipher_round_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [511:0] chain_in = '0, msg_in = '0, pt_in = '0, rk_in;
  logic [3:0]   key_round;
  logic [511:0] result;
  logic         done;
  int           checks = 0, errors = 0;
  logic [7:0]   sbt [256];
  logic [127:0] rks [4][11];
  logic [63:0]  seed = 64'h0123_4567_89ab_cdef;

  always #4 clk = ~clk;

  hash_cipher_round dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .chain_in(chain_in), .msg_in(msg_in), .pt_in(pt_in), .rk_in(rk_in),
    .key_round(key_round), .result(result), .done(done)
  );

  always_comb
    for (int L = 0; L < 4; L++) rk_in[511-128*L -: 128] = rks[L][key_round];

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  task automatic build_sbox();
    logic [7:0] inv, s, cst;
    cst = 8'h63;
    for (int a = 0; a < 256; a++) begin
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ cst[i];
      sbt[a] = s;
    end
  endtask

  task automatic set_key(input int L, input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sbt[t[23:16]], sbt[t[15:8]], sbt[t[7:0]], sbt[t[31:24]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rks[L][r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] aes_ref(input logic [127:0] pt, input int L);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o, k;
    k = rks[L][0];
    for (int j = 0; j < 16; j++) s[j] = pt[127-8*j -: 8] ^ k[127-8*j -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int j = 0; j < 16; j++) s[j] = sbt[s[j]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[4*c+r] = (rd < 10) ? gm(8'h02, t[4*c+r]) ^ gm(8'h03, t[4*c+(r+1)%4]) ^
                                 t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4] : t[4*c+r];
      k = rks[L][rd];
      for (int j = 0; j < 16; j++) s[j] = s[j] ^ k[127-8*j -: 8];
    end
    for (int j = 0; j < 16; j++) o[127-8*j -: 8] = s[j];
    return o;
  endfunction

  function automatic logic [511:0] aes_all(input logic [511:0] p);
    logic [511:0] o;
    for (int L = 0; L < 4; L++) o[511-128*L -: 128] = aes_ref(p[511-128*L -: 128], L);
    return o;
  endfunction

  function automatic logic [511:0] gperm(input logic [511:0] x, input bit q);
    logic [7:0] a [64];
    logic [7:0] b [64];
    int qs [8];
    int cf [8];
    logic [511:0] o;
    qs = '{1, 3, 5, 7, 0, 2, 4, 6};
    cf = '{2, 2, 3, 4, 5, 3, 5, 7};
    for (int k = 0; k < 64; k++) a[k] = x[511-8*k -: 8];
    for (int rd = 0; rd < 10; rd++) begin
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++) begin
          if (q) begin
            a[8*c+r] = a[8*c+r] ^ 8'hff;
            if (r == 7) a[8*c+r] = a[8*c+r] ^ 8'(c * 16 + rd);
          end else if (r == 0) a[8*c+r] = a[8*c+r] ^ 8'(c * 16 + rd);
        end
      for (int k = 0; k < 64; k++) a[k] = sbt[a[k]];
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++) b[8*c+r] = a[8*((c + (q ? qs[r] : r)) % 8) + r];
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++) begin
          a[8*c+r] = 8'h00;
          for (int j = 0; j < 8; j++)
            a[8*c+r] = a[8*c+r] ^ gm(8'(cf[(j - r + 8) % 8]), b[8*c+j]);
        end
    end
    for (int k = 0; k < 64; k++) o[511-8*k -: 8] = a[k];
    return o;
  endfunction

  function automatic logic [511:0] href(input logic [511:0] h, input logic [511:0] m);
    return gperm(h ^ m, 1'b0) ^ gperm(m, 1'b1) ^ h;
  endfunction

  task automatic rnd512(output logic [511:0] v);
    for (int i = 0; i < 8; i++) begin
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      v[64*i +: 64] = seed ^ (seed >> 29);
    end
  endtask

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_job(input bit md, input bit pre, input int inject, input bit hold,
                         input logic [511:0] holdval, output int lat);
    lat = 0;
    if (!pre) begin
      @(negedge clk);
      mode  = md;
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 60) begin
      if (md) chk("R6 key_round during run", 512'(key_round), 512'(lat + 1));
      if (hold) chk("R9 result held during next run", result, holdval);
      if (lat == inject) begin
        start = 1'b1;
        mode  = ~md;
        pt_in = ~pt_in;
        chain_in = ~chain_in;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (lat >= 60) chk("watchdog: done never rose", 512'(0), 512'(1));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] v, v2, prev, exp, h, m;
    int lat;
    build_sbox();
    for (int L = 0; L < 4; L++) set_key(L, '0);
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 512'(done), 512'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 512'(done), 512'(0));
    chk("R1 result after reset", result, '0);
    chk("R1 key_round after reset", 512'(key_round), 512'(0));

    rnd512(v);
    rnd512(v2);
    set_key(0, 128'h000102030405060708090a0b0c0d0e0f);
    set_key(1, 128'h2b7e151628aed2a6abf7158809cf4f3c);
    set_key(2, v[127:0]);
    set_key(3, v[255:128]);
    pt_in = {128'h00112233445566778899aabbccddeeff, 128'h3243f6a8885a308d313198a2e0370734,
             v2[127:0], v2[255:128]};
    run_job(1'b1, 1'b0, -1, 1'b0, '0, lat);
    chk("R6 cipher latency", 512'(lat), 512'(10));
    chk("R5 lane0 known answer", 512'(result[511:384]), 512'(128'h69c4e0d86a7b0430d8cdb78070b4c55a));
    chk("R5 lane1 known answer", 512'(result[383:256]), 512'(128'h3925841d02dc09fbdc118597196a0b32));
    chk("R5 four lanes vs model", result, aes_all(pt_in));
    chk("R6 key_round zero at done", 512'(key_round), 512'(0));
    prev = result;
    @(negedge clk);
    chk("R10 done drops after one cycle", 512'(done), 512'(0));
    repeat (3) @(negedge clk);
    chk("R9 result held while idle", result, prev);

    pt_in[255:128] = ~pt_in[255:128];
    run_job(1'b1, 1'b0, -1, 1'b0, '0, lat);
    chk("R7 lanes 0 and 1 unchanged", 512'(result[511:256]), 512'(prev[511:256]));
    chk("R7 lane 3 unchanged", 512'(result[127:0]), 512'(prev[127:0]));
    chk("R7 lane 2 follows its plaintext", 512'(result[255:128]), 512'(aes_ref(pt_in[255:128], 2)));
    @(negedge clk);

    for (int p = 0; p < 6; p++) begin
      case (p)
        0: begin h = '0; m = '0; end
        1: begin h = '1; m = '0; end
        2: begin h = '0; m = '1; end
        default: begin rnd512(h); rnd512(m); end
      endcase
      chain_in = h;
      msg_in   = m;
      run_job(1'b0, 1'b0, -1, 1'b0, '0, lat);
      chk("R4 hash latency", 512'(lat), 512'(20));
      chk("R2/R3 compression vs model", result, href(h, m));
      @(negedge clk);
      chk("R10 done single cycle after hash", 512'(done), 512'(0));
    end

    rnd512(h); rnd512(m);
    chain_in = h; msg_in = m;
    run_job(1'b0, 1'b0, 5, 1'b0, '0, lat);
    chk("R8 hash latency with stray start", 512'(lat), 512'(20));
    chk("R8 hash result with stray start", result, href(h, m));
    @(negedge clk);

    rnd512(v);
    pt_in = v;
    exp = aes_all(v);
    run_job(1'b1, 1'b0, 3, 1'b0, '0, lat);
    chk("R8 cipher latency with stray start", 512'(lat), 512'(10));
    chk("R8 cipher result with stray start", result, exp);

    prev = result;
    rnd512(h); rnd512(m);
    chain_in = h; msg_in = m;
    mode  = 1'b0;
    start = 1'b1;
    run_job(1'b0, 1'b1, -1, 1'b1, prev, lat);
    chk("R9 start in done cycle accepted, latency", 512'(lat), 512'(20));
    chk("R9 chained hash result", result, href(h, m));
    @(negedge clk);
    chk("R10 done single cycle after chain", 512'(done), 512'(0));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule